// File: doc/BRIEF.md
# Pipeline Exception Capture Unit

This block sits beside the hazard logic of a five-stage in-order pipeline. It takes precise exceptions from two sources. The execute stage can report an arithmetic overflow, and the decode stage can report an undefined opcode. In the cycle an exception is raised, the unit takes it at once.

When it takes an exception, the unit does four things in that same cycle:
- it drives a redirect address for the program counter;
- it flushes the faulting stage and every younger stage, which zeroes their control fields as a bubble would;
- for an overflow, it stops the faulting instruction from writing its destination register;
- it selects which PC and which cause to record.

On the next clock edge, the link register holds the PC of the faulting instruction and the one-bit syndrome register holds the cause. The memory and writeback stages hold older instructions, so they receive no flush and complete normally.

The redirect address is the vector base input plus a six-bit offset chosen by cause: 6'b000000 for an undefined opcode and 6'b101100 (44) for an overflow. The addition wraps modulo 2^PC_W. All pins are plain level signals sampled each cycle. There is no data stream, so there is no valid/ready handshake and no back-pressure: the decision is combinational and is never delayed.

Top module: `exc_capture_unit`

## Requirements
- R1: After reset, `elr` is 0 and `esr` is 0.
- R2: In a cycle with `ex_ovf`=1, all of the following hold in that cycle: `take`=1, `flush_if`=`flush_id`=`flush_ex`=1, `kill_ex_wr`=1, and `redirect_pc` = `vec_base` + 44.
- R3: In a cycle with `id_undef`=1 and `ex_ovf`=0, all of the following hold in that cycle: `take`=1, `flush_if`=`flush_id`=1, `flush_ex`=0, `kill_ex_wr`=0, and `redirect_pc` = `vec_base` + 0.
- R4: When `ex_ovf` and `id_undef` are both 1, the overflow wins: the outputs are those of R2, and `ex_pc` is recorded with cause 1.
- R5: On the clock edge after an exception is taken, `elr` becomes the faulting PC and `esr` becomes the cause. The faulting PC is `ex_pc` for an overflow and `id_pc` for an undefined opcode. The cause is 1 for an overflow and 0 for an undefined opcode.
- R6: On an edge where no exception is taken, `elr` and `esr` keep their values.
- R7: With neither flag set, `take`, all three flush outputs and `kill_ex_wr` are 0.
- R8: `redirect_pc` wraps modulo 2^PC_W when `vec_base` plus the offset exceeds the PC range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_pc | input | PC_W | PC of the instruction in decode |
| id_undef | input | 1 | Undefined opcode in decode |
| ex_pc | input | PC_W | PC of the instruction in execute |
| ex_ovf | input | 1 | Arithmetic overflow in execute |
| vec_base | input | PC_W | Vector table base address |
| take | output | 1 | An exception is taken this cycle |
| redirect_pc | output | PC_W | Handler address to load into the PC |
| flush_if | output | 1 | Flush the fetch stage |
| flush_id | output | 1 | Flush the decode stage |
| flush_ex | output | 1 | Flush the execute stage |
| kill_ex_wr | output | 1 | Suppress the execute instruction's register write |
| elr | output | PC_W | Exception link register |
| esr | output | 1 | Syndrome bit: 0 undefined opcode, 1 overflow |

## Verification
An overflow in execute and an undefined opcode in decode can be reported in the same cycle. The bench raises both flags together, with different PCs in the two stages. The combinational outputs that cycle must be the overflow's: redirect to base+44, flush of execute and a write kill. On the following edge the bench confirms that the link register holds the execute PC rather than the decode PC, and that the syndrome bit is 1.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int OFFS_W = 6;

  typedef enum logic {
    CAUSE_UNDEF = 1'b0,
    CAUSE_OVF   = 1'b1
  } cause_e;

  function automatic logic [OFFS_W-1:0] cause_offset(cause_e c);
    return (c == CAUSE_OVF) ? 6'b101100 : 6'b000000;
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ex_ovf,
  input  logic            id_undef,
  input  logic [PC_W-1:0] ex_pc,
  input  logic [PC_W-1:0] id_pc,
  output logic            take,
  output cause_e          cause,
  output logic [PC_W-1:0] fault_pc,
  output logic            flush_if,
  output logic            flush_id,
  output logic            flush_ex,
  output logic            kill_wr
);
  // Execute holds the older instruction, so its fault is served first.
  always_comb begin
    take     = ex_ovf | id_undef;
    cause    = ex_ovf ? CAUSE_OVF : CAUSE_UNDEF;
    fault_pc = ex_ovf ? ex_pc : id_pc;
    flush_if = take;
    flush_id = take;
    flush_ex = ex_ovf;
    kill_wr  = ex_ovf;
  end

  // R4: execute fault wins over a decode fault in the same cycle
  a_r4_ex_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_ovf && id_undef) |-> (fault_pc == ex_pc && cause == CAUSE_OVF));
  // R3: a decode fault leaves the older execute instruction alone
  a_r3_ex_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (id_undef && !ex_ovf) |-> (!flush_ex && !kill_wr && flush_id));
  // R7: quiet pipeline means no flush
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_ovf && !id_undef) |-> !(take || flush_if || flush_id || flush_ex || kill_wr));
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0] vec_base,
  input  cause_e          cause,
  output logic [PC_W-1:0] handler_pc
);
  localparam int PAD_W = PC_W - OFFS_W;

  logic [PC_W-1:0] offs_ext;

  always_comb begin
    offs_ext   = {{PAD_W{1'b0}}, cause_offset(cause)};
    handler_pc = vec_base + offs_ext;
  end
endmodule

// File: rtl/exc_regs.sv
module exc_regs
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  cause_e          cause,
  input  logic [PC_W-1:0] fault_pc,
  output logic [PC_W-1:0] elr,
  output logic            esr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elr <= '0;
      esr <= 1'b0;
    end else if (take) begin
      elr <= fault_pc;
      esr <= cause;
    end
  end

  // R6: registers hold when nothing is taken
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(elr) && $stable(esr)));
  // R5: capture of the faulting PC one edge later
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (elr == $past(fault_pc) && esr == $past(cause)));
endmodule

// File: rtl/exc_capture_unit.sv
module exc_capture_unit
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] id_pc,
  input  logic            id_undef,
  input  logic [PC_W-1:0] ex_pc,
  input  logic            ex_ovf,
  input  logic [PC_W-1:0] vec_base,
  output logic            take,
  output logic [PC_W-1:0] redirect_pc,
  output logic            flush_if,
  output logic            flush_id,
  output logic            flush_ex,
  output logic            kill_ex_wr,
  output logic [PC_W-1:0] elr,
  output logic            esr
);
  cause_e          sel_cause;
  logic [PC_W-1:0] sel_pc;

  exc_arbiter #(.PC_W(PC_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .ex_ovf(ex_ovf), .id_undef(id_undef),
    .ex_pc(ex_pc), .id_pc(id_pc),
    .take(take), .cause(sel_cause), .fault_pc(sel_pc),
    .flush_if(flush_if), .flush_id(flush_id), .flush_ex(flush_ex),
    .kill_wr(kill_ex_wr)
  );

  exc_vector #(.PC_W(PC_W)) u_vec (
    .vec_base(vec_base), .cause(sel_cause), .handler_pc(redirect_pc)
  );

  exc_regs #(.PC_W(PC_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .take(take), .cause(sel_cause), .fault_pc(sel_pc),
    .elr(elr), .esr(esr)
  );

  // R2: overflow redirects 44 bytes past the base and kills the write
  a_r2_ovf_vector: assert property (@(posedge clk) disable iff (!rst_n)
    ex_ovf |-> ((redirect_pc - vec_base) == PC_W'(44) && kill_ex_wr && flush_ex));
  // R3: decode fault redirects to the base itself
  a_r3_undef_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (id_undef && !ex_ovf) |-> (redirect_pc == vec_base));
endmodule

// File: tb/exc_capture_unit_test.sv
`timescale 1ns/100ps
module exc_capture_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] id_pc = '0, ex_pc = '0, vec_base = '0;
  logic        id_undef = 1'b0, ex_ovf = 1'b0;
  logic        take, flush_if, flush_id, flush_ex, kill_ex_wr, esr;
  logic [31:0] redirect_pc, elr;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_elr = '0;
  logic        m_esr = 1'b0;

  always #2.5 clk = ~clk;

  exc_capture_unit #(.PC_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .id_pc(id_pc), .id_undef(id_undef),
    .ex_pc(ex_pc), .ex_ovf(ex_ovf), .vec_base(vec_base),
    .take(take), .redirect_pc(redirect_pc), .flush_if(flush_if),
    .flush_id(flush_id), .flush_ex(flush_ex), .kill_ex_wr(kill_ex_wr),
    .elr(elr), .esr(esr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one cycle of stimulus and compare against the reference model.
  task automatic step(input logic o, input logic u, input logic [31:0] ip,
                      input logic [31:0] ep, input logic [31:0] vb);
    logic        e_take;
    logic [31:0] e_pc;
    string       tg, rt;
    @(negedge clk);
    ex_ovf = o; id_undef = u; id_pc = ip; ex_pc = ep; vec_base = vb;
    #1;
    // state captured on earlier edges
    rt = (take === 1'b1) ? "R5" : "R6";
    chk("R5/R6", "elr", elr, m_elr);
    chk("R5/R6", "esr", {31'b0, esr}, {31'b0, m_esr});
    e_take = o | u;
    e_pc   = o ? ep : ip;
    tg = (o && u) ? "R4" : o ? "R2" : u ? "R3" : "R7";
    chk(tg, "take", {31'b0, take}, {31'b0, e_take});
    chk(tg, "flush_if", {31'b0, flush_if}, {31'b0, e_take});
    chk(tg, "flush_id", {31'b0, flush_id}, {31'b0, e_take});
    chk(tg, "flush_ex", {31'b0, flush_ex}, {31'b0, o});
    chk(tg, "kill_ex_wr", {31'b0, kill_ex_wr}, {31'b0, o});
    if (e_take) begin
      if (vb > 32'hFFFF_FFC0) tg = "R8";
      chk(tg, "redirect_pc", redirect_pc, vb + (o ? 32'd44 : 32'd0));
      m_elr = e_pc;
      m_esr = o;
    end
    if (rt.len() == 0) n_chk = n_chk;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "elr after reset", elr, 32'h0);
    chk("R1", "esr after reset", {31'b0, esr}, 32'h0);
    step(0, 0, 32'h100, 32'h0FC, 32'h8000_0000);   // R7 quiet
    step(1, 0, 32'h150, 32'h14C, 32'h8000_0180);   // R2 overflow
    step(0, 0, 32'h154, 32'h150, 32'h8000_0180);   // R6 hold
    step(0, 0, 32'h158, 32'h154, 32'h8000_0180);   // R6 hold
    step(0, 1, 32'h200, 32'h1FC, 32'h4000_0000);   // R3 undefined opcode
    step(0, 0, 32'h204, 32'h200, 32'h4000_0000);
    step(1, 1, 32'h304, 32'h300, 32'h1000_0000);   // R4 both at once
    step(0, 0, 32'h308, 32'h304, 32'h1000_0000);
    step(1, 0, 32'h400, 32'h3FC, 32'hFFFF_FFE0);   // R8 wrap on overflow
    step(0, 1, 32'h404, 32'h400, 32'hFFFF_FFF0);   // R8 undef near top
    step(0, 1, 32'h408, 32'h404, 32'h2000_0000);   // back-to-back R3
    step(1, 0, 32'h40C, 32'h408, 32'h2000_0000);   // R2 then R5 capture
    step(0, 0, 32'h410, 32'h40C, 32'h2000_0000);
    step(0, 0, 32'h414, 32'h410, 32'h2000_0000);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule